// File: doc/BRIEF.md
# NAND Flash Controller Register and Completion Unit

This block is the 16-bit register file that sits between a processor bus and a NAND flash sequencing engine. Software writes the flash command and address values, picks a buffer and a target chip, and sets the geometry. It then writes a trigger register, and the block starts exactly one engine operation. When the engine reports that it has finished, the block sets a sticky completion flag and, unless masked, raises an interrupt. Software clears the flag by writing the trigger register with its top bit low.

The block also has a self-clearing soft reset of the operation state. It drives the one-hot chip-enable lines and the decoded pages-per-block count. A small write-protect state machine with a block range guards programming; once it is placed in its tight-lock state, only a hardware reset releases it. Reads return data one clock after the address is presented.

Top module: `flashctl_regs`

## Requirements
- R1: After reset, the control register reads 0x0010 (interrupt masked) and the write-protect register reads 0x0002 (locked). The trigger register and all other registers read 0, and irq, op_start and chip_en are low.
- R2: Writing word address 3 (trigger) while idle pulses op_start for one cycle after the write edge. It drives op_kind with the index of the lowest set bit among bits 5:0: 0 command, 1 address, 2 data in, 3 data out, 4 ID read, 5 status read. A write with none of those bits set starts nothing.
- R3: A trigger write that arrives while an operation runs or while the soft reset is active starts nothing. While an operation runs, trigger bits 5:0 read back one-hot at the position of the running operation.
- R4: Trigger bit 15 is the completion flag. eng_done sets it only while an operation runs, and that also ends the operation. It stays set until a trigger write with bit 15 low. If eng_done and that write arrive in the same cycle, the flag is set.
- R5: irq is high one cycle after the completion flag is set, provided control bit 4 (mask) is 0. While the mask is 1, irq is low and the flag is unaffected.
- R6: Writing control bit 6 starts a soft reset. The bit reads 1 for exactly 8 cycles after the write edge and then 0. During that time the completion flag and the running operation are cleared.
- R7: When control bit 7 is 1, chip_en is one-hot at the index held in bits 6:5 of word address 0 (buffer select); otherwise chip_en is 0. buf_idx follows bits 2:0 of that register. These outputs change one cycle after the register does.
- R8: pages_per_blk is 32, 64, 128 or 256 for control bits 10:9 equal to 0, 1, 2 or 3. big_endian follows control bit 5. Both change one cycle after the register does.
- R9: Write-protect writes at word address 6 act by priority: bit 0 gives tight lock, otherwise bit 1 gives lock, otherwise bit 2 gives unlock. The state reads back one-hot: 0x0001 tight, 0x0002 locked, 0x0004 unlocked.
- R10: In tight lock, write-protect writes and writes to the range start (address 7) and range end (address 8) are ignored until a hardware reset.
- R11: The map is 0 buffer select (bits 6:5 and 2:0 stored), 1 flash address, 2 flash command, 4 control (bits 11:0 except 6 stored), 5 spare size in 16-bit units, 7 and 8 unlock range. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after address |
| op_start | output | 1 | One-cycle operation start pulse |
| op_kind | output | 3 | Operation code for the started operation |
| eng_done | input | 1 | Engine finished the running operation |
| irq | output | 1 | Completion interrupt |
| chip_en | output | NUM_CS | One-hot chip enables |
| buf_idx | output | BUF_W | Selected buffer index |
| pages_per_blk | output | 9 | Decoded pages per erase block |
| big_endian | output | 1 | Byte-order select for transfers |

## Verification
Register writes take effect at the write edge, and read data is registered, so a read is due one edge after its address. op_start and op_kind appear right after the trigger edge. irq, chip_en, buf_idx, pages_per_blk and big_endian lag the state that produces them by one more edge. The bench drives inputs and samples outputs on falling edges. It counts edges from each write to the sample point: it checks op_start at the first falling edge after the write, and it waits one extra cycle for the lagged outputs. For the soft reset it reads the control register on the 8th and 9th edges after the write to pin the exact length.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int N_OPS    = 6;
  localparam int DONE_BIT = 15;

  localparam int A_BUFSEL = 0;
  localparam int A_FADDR  = 1;
  localparam int A_FCMD   = 2;
  localparam int A_TRIG   = 3;
  localparam int A_CTRL   = 4;
  localparam int A_SPARE  = 5;
  localparam int A_WPCMD  = 6;
  localparam int A_ULK_LO = 7;
  localparam int A_ULK_HI = 8;

  localparam int C_MASK   = 4;
  localparam int C_BE     = 5;
  localparam int C_SRST   = 6;
  localparam int C_CE     = 7;
  localparam int C_PPB    = 9;
  localparam int CS_LSB   = 5;

  localparam logic [15:0] CTRL_WMASK = 16'h0FBF;
  localparam logic [15:0] CTRL_INIT  = 16'h0010;

  typedef enum logic [2:0] {
    OPK_CMD, OPK_ADDR, OPK_DIN, OPK_DOUT, OPK_ID, OPK_STAT
  } opk_e;

  typedef enum logic [2:0] {
    WPS_TIGHT = 3'b001,
    WPS_LOCK  = 3'b010,
    WPS_OPEN  = 3'b100
  } wps_e;
endpackage

// File: rtl/fcr_srst.sv
module fcr_srst #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic active
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (kick)         cnt_q <= CW'(RST_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/fcr_opctl.sv
module fcr_opctl
  import fcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_we,
  input  logic [N_OPS-1:0] trig_ops,
  input  logic             trig_keep,
  input  logic             eng_done,
  input  logic             hold,
  input  logic             mask,
  output logic             op_start,
  output logic [2:0]       op_kind,
  output logic             busy,
  output logic             done,
  output logic [N_OPS-1:0] run_oh,
  output logic             irq
);
  logic       found;
  logic [2:0] pick;
  logic       launch;
  logic       finish;
  opk_e       kind_q;

  // lowest-numbered requested operation wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < N_OPS; i++) begin
      if (!found && trig_ops[i]) begin
        found = 1'b1;
        pick  = 3'(i);
      end
    end
  end

  assign launch = trig_we && found && !busy && !hold;
  assign finish = busy && eng_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_start <= 1'b0;
      kind_q   <= OPK_CMD;
      busy     <= 1'b0;
      done     <= 1'b0;
      run_oh   <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= done && !mask;
      if (hold) begin
        op_start <= 1'b0;
        busy     <= 1'b0;
        done     <= 1'b0;
        run_oh   <= '0;
      end else begin
        op_start <= launch;
        if (launch) begin
          busy   <= 1'b1;
          kind_q <= opk_e'(pick);
          run_oh <= N_OPS'(1) << pick;
        end else if (finish) begin
          busy   <= 1'b0;
          run_oh <= '0;
        end
        if (finish)                      done <= 1'b1;
        else if (trig_we && !trig_keep)  done <= 1'b0;
      end
    end
  end

  assign op_kind = kind_q;
endmodule

// File: rtl/fcr_wprot.sv
module fcr_wprot
  import fcr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_we,
  input  logic        lo_we,
  input  logic        hi_we,
  input  logic [15:0] wdata,
  output logic [2:0]  state,
  output logic [15:0] ulk_lo,
  output logic [15:0] ulk_hi
);
  wps_e st_q;
  logic tight;

  assign tight = (st_q == WPS_TIGHT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= WPS_LOCK;
      ulk_lo <= '0;
      ulk_hi <= '0;
    end else if (!tight) begin
      if (cmd_we) begin
        if (wdata[0])      st_q <= WPS_TIGHT;
        else if (wdata[1]) st_q <= WPS_LOCK;
        else if (wdata[2]) st_q <= WPS_OPEN;
      end
      if (lo_we) ulk_lo <= wdata;
      if (hi_we) ulk_hi <= wdata;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/flashctl_regs.sv
module flashctl_regs
  import fcr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int NUM_CS     = 4,
  parameter int BUF_W      = 3,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              op_start,
  output logic [2:0]        op_kind,
  input  logic              eng_done,
  output logic              irq,
  output logic [NUM_CS-1:0] chip_en,
  output logic [BUF_W-1:0]  buf_idx,
  output logic [8:0]        pages_per_blk,
  output logic              big_endian
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam logic [15:0] SEL_MASK =
    16'((1 << BUF_W) - 1) | 16'(((1 << CS_W) - 1) << CS_LSB);

  logic [15:0] bufsel_q, faddr_q, fcmd_q, ctrl_q, spare_q;
  logic [15:0] rd_next;
  logic [2:0]  wp_state;
  logic [15:0] ulk_lo, ulk_hi;
  logic [N_OPS-1:0] run_oh;
  logic        srst_active, busy, done;
  logic        we_bufsel, we_faddr, we_fcmd, we_trig, we_ctrl, we_spare;
  logic        we_wp, we_lo, we_hi;

  assign we_bufsel = reg_we && (reg_addr == ADDR_W'(A_BUFSEL));
  assign we_faddr  = reg_we && (reg_addr == ADDR_W'(A_FADDR));
  assign we_fcmd   = reg_we && (reg_addr == ADDR_W'(A_FCMD));
  assign we_trig   = reg_we && (reg_addr == ADDR_W'(A_TRIG));
  assign we_ctrl   = reg_we && (reg_addr == ADDR_W'(A_CTRL));
  assign we_spare  = reg_we && (reg_addr == ADDR_W'(A_SPARE));
  assign we_wp     = reg_we && (reg_addr == ADDR_W'(A_WPCMD));
  assign we_lo     = reg_we && (reg_addr == ADDR_W'(A_ULK_LO));
  assign we_hi     = reg_we && (reg_addr == ADDR_W'(A_ULK_HI));

  always_ff @(posedge clk) begin
    if (rst) begin
      bufsel_q <= '0;
      faddr_q  <= '0;
      fcmd_q   <= '0;
      ctrl_q   <= CTRL_INIT;
      spare_q  <= '0;
    end else begin
      if (we_bufsel) bufsel_q <= reg_wdata & SEL_MASK;
      if (we_faddr)  faddr_q  <= reg_wdata;
      if (we_fcmd)   fcmd_q   <= reg_wdata;
      if (we_ctrl)   ctrl_q   <= reg_wdata & CTRL_WMASK;
      if (we_spare)  spare_q  <= reg_wdata;
    end
  end

  fcr_srst #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk    (clk),
    .rst    (rst),
    .kick   (we_ctrl && reg_wdata[C_SRST]),
    .active (srst_active)
  );

  fcr_opctl u_opctl (
    .clk       (clk),
    .rst       (rst),
    .trig_we   (we_trig),
    .trig_ops  (reg_wdata[N_OPS-1:0]),
    .trig_keep (reg_wdata[DONE_BIT]),
    .eng_done  (eng_done),
    .hold      (srst_active),
    .mask      (ctrl_q[C_MASK]),
    .op_start  (op_start),
    .op_kind   (op_kind),
    .busy      (busy),
    .done      (done),
    .run_oh    (run_oh),
    .irq       (irq)
  );

  fcr_wprot u_wprot (
    .clk    (clk),
    .rst    (rst),
    .cmd_we (we_wp),
    .lo_we  (we_lo),
    .hi_we  (we_hi),
    .wdata  (reg_wdata),
    .state  (wp_state),
    .ulk_lo (ulk_lo),
    .ulk_hi (ulk_hi)
  );

  // registered configuration outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      chip_en       <= '0;
      buf_idx       <= '0;
      pages_per_blk <= 9'd32;
      big_endian    <= 1'b0;
    end else begin
      chip_en       <= ctrl_q[C_CE] ? (NUM_CS'(1) << bufsel_q[CS_LSB +: CS_W]) : '0;
      buf_idx       <= bufsel_q[BUF_W-1:0];
      pages_per_blk <= 9'd32 << ctrl_q[C_PPB +: 2];
      big_endian    <= ctrl_q[C_BE];
    end
  end

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      ADDR_W'(A_BUFSEL): rd_next = bufsel_q;
      ADDR_W'(A_FADDR):  rd_next = faddr_q;
      ADDR_W'(A_FCMD):   rd_next = fcmd_q;
      ADDR_W'(A_TRIG):   rd_next = {done, (15 - N_OPS)'(0), run_oh};
      ADDR_W'(A_CTRL):   rd_next = ctrl_q | (16'(srst_active) << C_SRST);
      ADDR_W'(A_SPARE):  rd_next = spare_q;
      ADDR_W'(A_WPCMD):  rd_next = {13'd0, wp_state};
      ADDR_W'(A_ULK_LO): rd_next = ulk_lo;
      ADDR_W'(A_ULK_HI): rd_next = ulk_hi;
      default:           rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/fcr_chk.sv
module fcr_chk
  import fcr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [15:0]       reg_wdata,
  input logic              op_start,
  input logic              irq,
  input logic [NUM_CS-1:0] chip_en,
  input logic              srst_active,
  input logic              busy,
  input logic              done,
  input logic [15:0]       ctrl_q,
  input logic [2:0]        wp_state
);
  logic clr_wr;
  assign clr_wr = reg_we && (reg_addr == ADDR_W'(A_TRIG)) && !reg_wdata[DONE_BIT];

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    op_start |=> !op_start);

  p_no_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> !op_start);

  p_done_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !srst_active && !clr_wr) |=> done);

  p_irq_masked_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[C_MASK] |=> !irq);

  p_srst_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    srst_active |=> (!done && !op_start));

  p_chip_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chip_en));

  p_tight_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (wp_state == 3'b001) |=> (wp_state == 3'b001));
endmodule

bind flashctl_regs fcr_chk #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .op_start    (op_start),
  .irq         (irq),
  .chip_en     (chip_en),
  .srst_active (srst_active),
  .busy        (busy),
  .done        (done),
  .ctrl_q      (ctrl_q),
  .wp_state    (wp_state)
);

// File: tb/flashctl_regs_tb.sv
module flashctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        op_start;
  logic [2:0]  op_kind;
  logic        eng_done = 1'b0;
  logic        irq;
  logic [3:0]  chip_en;
  logic [2:0]  buf_idx;
  logic [8:0]  pages_per_blk;
  logic        big_endian;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [15:0] rv;

  always #5 clk = ~clk;

  flashctl_regs u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .op_start(op_start),
    .op_kind(op_kind), .eng_done(eng_done), .irq(irq), .chip_en(chip_en),
    .buf_idx(buf_idx), .pages_per_blk(pages_per_blk), .big_endian(big_endian)
  );

  typedef struct packed {
    logic [3:0]  wa;
    logic [15:0] wd;
    logic [3:0]  ra;
    logic [15:0] ex;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{4'd0,  16'hFFFF, 4'd0,  16'h0067},
    '{4'd1,  16'hA5C3, 4'd1,  16'hA5C3},
    '{4'd2,  16'h0070, 4'd2,  16'h0070},
    '{4'd5,  16'h0020, 4'd5,  16'h0020},
    '{4'd4,  16'h0F90, 4'd4,  16'h0F90},
    '{4'd15, 16'h1234, 4'd15, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic eng_pulse();
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    rd(4'd4, rv); chk("R1 ctrl", rv, 16'h0010);
    rd(4'd6, rv); chk("R1 wp", rv, 16'h0002);
    rd(4'd3, rv); chk("R1 trig", rv, 16'h0000);
    chk("R1 outs", {11'd0, irq, op_start, chip_en}, 16'h0000);
    chk("R8 reset ppb", 16'(pages_per_blk), 16'd32);

    // R11 table of plain registers
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i].wa, VEC[i].wd);
      rd(VEC[i].ra, rv);
      chk($sformatf("R11 vec%0d", i), rv, VEC[i].ex);
    end
    idle(1);
    chk("R7 chip_en cs3", 16'(chip_en), 16'h0008);
    chk("R7 buf_idx", 16'(buf_idx), 16'h0007);
    chk("R8 ppb 256", 16'(pages_per_blk), 16'd256);
    wr(4'd4, 16'h0420);
    idle(1);
    chk("R7 ce off", 16'(chip_en), 16'h0000);
    chk("R8 ppb 128", 16'(pages_per_blk), 16'd128);
    chk("R8 big_endian", 16'(big_endian), 16'h0001);

    // R2 start command op
    wr(4'd3, 16'h0001);
    chk("R2 start", 16'(op_start), 16'h0001);
    chk("R2 kind cmd", 16'(op_kind), 16'h0000);
    idle(1);
    chk("R2 pulse ends", 16'(op_start), 16'h0000);
    // R3 trigger while busy
    wr(4'd3, 16'h0004);
    chk("R3 busy ignore", 16'(op_start), 16'h0000);
    rd(4'd3, rv); chk("R3 run onehot", rv, 16'h0001);
    // R4 done, R5 irq
    eng_pulse();
    rd(4'd3, rv); chk("R4 done set", rv, 16'h8000);
    chk("R5 irq high", 16'(irq), 16'h0001);
    wr(4'd3, 16'h8000);
    rd(4'd3, rv); chk("R4 keep on bit15", rv, 16'h8000);
    // R2 lowest of several
    wr(4'd3, 16'h0018);
    chk("R2 multi start", 16'(op_start), 16'h0001);
    chk("R2 lowest kind", 16'(op_kind), 16'h0003);
    idle(1);
    chk("R4 clear drops irq", 16'(irq), 16'h0000);
    eng_pulse();
    wr(4'd4, 16'h0010);
    idle(1);
    chk("R5 masked irq", 16'(irq), 16'h0000);
    rd(4'd3, rv); chk("R5 flag kept", rv, 16'h8000);
    wr(4'd3, 16'h0000);
    rd(4'd3, rv); chk("R4 cleared", rv, 16'h0000);
    eng_pulse();
    rd(4'd3, rv); chk("R4 idle done ignored", rv, 16'h0000);
    // R4 set wins over clear
    wr(4'd3, 16'h0020);
    chk("R2 kind status", 16'(op_kind), 16'h0005);
    reg_addr = 4'd3; reg_wdata = 16'h0000; reg_we = 1'b1; eng_done = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; eng_done = 1'b0;
    rd(4'd3, rv); chk("R4 set wins", rv, 16'h8000);

    // R6 soft reset
    wr(4'd4, 16'h0050);
    rd(4'd4, rv); chk("R6 bit set", rv, 16'h0050);
    wr(4'd3, 16'h0002);
    chk("R6 R3 no start in reset", 16'(op_start), 16'h0000);
    idle(5);
    rd(4'd4, rv); chk("R6 8th edge", rv, 16'h0050);
    rd(4'd4, rv); chk("R6 9th edge", rv, 16'h0010);
    rd(4'd3, rv); chk("R6 done cleared", rv, 16'h0000);
    wr(4'd3, 16'h0002);
    chk("R6 start after", 16'(op_kind), 16'h0001);
    eng_pulse();

    // R9 write protect
    wr(4'd6, 16'h0006);
    rd(4'd6, rv); chk("R9 lock over unlock", rv, 16'h0002);
    wr(4'd6, 16'h0004);
    rd(4'd6, rv); chk("R9 unlock", rv, 16'h0004);
    wr(4'd7, 16'h0000);
    wr(4'd8, 16'hFFFF);
    rd(4'd8, rv); chk("R9 range end", rv, 16'hFFFF);
    wr(4'd6, 16'h0007);
    rd(4'd6, rv); chk("R9 tight", rv, 16'h0001);
    // R10 tight is sticky
    wr(4'd6, 16'h0004);
    rd(4'd6, rv); chk("R10 unlock ignored", rv, 16'h0001);
    wr(4'd8, 16'h1234);
    rd(4'd8, rv); chk("R10 range frozen", rv, 16'hFFFF);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    rd(4'd6, rv); chk("R10 hw reset frees", rv, 16'h0002);

    summary();
  end
endmodule